// File: doc/BRIEF.md
# Per-Channel DMA Command and Status Register Bank

This block is the control and status register bank of a DMA controller with up to 64 channels. For each channel it holds four bits: error-interrupt enable, interrupt request, error flag and a start strobe. It also holds one latched global error word. Software never runs a read-modify-write on a channel bitmap. To change the bit of one channel, it writes that channel's number to one of five command addresses. Pending interrupt requests and errors can also be cleared in bulk by writing ones to the 32-bit high or low status views.

The channel engines report on the hardware side. A completion pulse on `done_i[c]` raises the interrupt request of channel c. An error pulse on `err_i[c]`, together with a cause vector `err_info_i`, raises the channel's error flag and can fill the global error word. The block drives a single interrupt line, which is the OR of all pending requests and all enabled errors. It also drives a one-cycle start strobe for each channel to its engine. Reads are combinational from the register address. Writes take effect at the next clock edge.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every enable, request, error and start bit is 0, the global error word reads 0, `irq_o` is 0 and `start_o` is 0.
- R2: The channel number is taken from `wdata_i[7:0]`. A write to address 8 sets the error-interrupt enable of that channel and a write to address 9 clears it. Enables read back at address 1 (channels 63..32, bit c-32) and at address 2 (channels 31..0, bit c).
- R3: A pulse on `done_i[c]` sets the interrupt request of channel c. A write of c to address 10 clears it. When the clear arrives in the same cycle as a new completion, the request stays set. Requests read back at address 3 (high) and address 4 (low), with the same bit layout as R2.
- R4: A pulse on `err_i[c]` sets the error flag of channel c only if that channel's enable was set before the cycle. A write of c to address 11 clears the flag. Error flags read back at address 5 (high) and address 6 (low).
- R5: Writing to addresses 3, 4, 5 or 6 clears each request or error bit of that half whose data bit is 1. Bits written as 0 are kept, so writing all ones clears the whole half.
- R6: The global error word at address 0 has bit 31 = valid, bits 15:14 = `err_info_i[9:8]` (group and channel priority errors), bits 13:8 = channel number and bits 7:0 = `err_info_i[7:0]` (cause flags). It captures an error only while valid is 0, whatever the channel's enable. When several channels error in the same cycle, the lowest-numbered one is recorded. It holds its value while valid is 1.
- R7: A clear-error command (address 11) naming the recorded channel resets the global error word to 0. A clear-error command naming any other channel, or a write to addresses 5 or 6, leaves the word unchanged.
- R8: A command write (addresses 8 to 12) whose channel number is at or above the configured channel count changes no state and produces no start strobe.
- R9: A write of c to address 12 drives `start_o[c]` high for exactly the one cycle after the write. The strobe is low in the following cycle unless the command is repeated.
- R10: `irq_o` is 1 exactly when some interrupt request is set, or some error flag is set while its channel enable is set. Clearing an enable masks that channel's error from `irq_o`, and the error flag stays readable.
- R11: With a channel count of 32 or less, addresses 1, 3 and 5 read 0, and commands that name channels at or above the count are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 32 | Write data; the channel number sits in bits 7:0 for commands |
| rdata_o | output | 32 | Read data for `addr_i` |
| done_i | input | NUM_CH | Per-channel completion pulses |
| err_i | input | NUM_CH | Per-channel error pulses |
| err_info_i | input | 10 | Error cause: priority errors in 9:8, cause flags in 7:0 |
| start_o | output | NUM_CH | Per-channel start strobe |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check the following on every cycle. The start strobe is at most one-hot and only follows a start command. A latched error word changes only when a clear-error command arrives. A new error flag always traces back to an enabled error input. An out-of-range command leaves the enables untouched. A completion always raises the interrupt in the next cycle. Some properties need chosen values and can only be shown by the bench scenarios: that the lowest channel wins a same-cycle error tie, that a clear naming a different channel leaves the latch alone, that a same-cycle completion beats a clear, the exact high/low bit placement, selective write-one-to-clear, and the 16-channel configuration with its zero high views.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int MAX_CH = 64;
  localparam int HALF_W = 32;
  localparam int CH_W   = $clog2(MAX_CH);
  localparam int INFO_W = 10;

  typedef enum logic [3:0] {
    REG_STATUS    = 4'd0,
    REG_EEI_HI    = 4'd1,
    REG_EEI_LO    = 4'd2,
    REG_INT_HI    = 4'd3,
    REG_INT_LO    = 4'd4,
    REG_ERR_HI    = 4'd5,
    REG_ERR_LO    = 4'd6,
    CMD_SET_EEI   = 4'd8,
    CMD_CLR_EEI   = 4'd9,
    CMD_CLR_INT   = 4'd10,
    CMD_CLR_ERR   = 4'd11,
    CMD_SET_START = 4'd12
  } reg_addr_e;
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [NUM_CH-1:0] set_eei_o,
  output logic [NUM_CH-1:0] clr_eei_o,
  output logic [NUM_CH-1:0] clr_int_o,
  output logic [NUM_CH-1:0] clr_err_o,
  output logic [NUM_CH-1:0] set_start_o,
  output logic [NUM_CH-1:0] w1c_int_o,
  output logic [NUM_CH-1:0] w1c_err_o
);
  logic [NUM_CH-1:0] sel;

  // channel select is one-hot only for in-range numbers
  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign sel[c] = (wdata_i[7:0] == 8'(c));
    if (c < HALF_W) begin : g_lo
      assign w1c_int_o[c] = we_i && (addr_i == REG_INT_LO) && wdata_i[c];
      assign w1c_err_o[c] = we_i && (addr_i == REG_ERR_LO) && wdata_i[c];
    end else begin : g_hi
      assign w1c_int_o[c] = we_i && (addr_i == REG_INT_HI) && wdata_i[c-HALF_W];
      assign w1c_err_o[c] = we_i && (addr_i == REG_ERR_HI) && wdata_i[c-HALF_W];
    end
  end

  assign set_eei_o   = (we_i && addr_i == CMD_SET_EEI)   ? sel : '0;
  assign clr_eei_o   = (we_i && addr_i == CMD_CLR_EEI)   ? sel : '0;
  assign clr_int_o   = (we_i && addr_i == CMD_CLR_INT)   ? sel : '0;
  assign clr_err_o   = (we_i && addr_i == CMD_CLR_ERR)   ? sel : '0;
  assign set_start_o = (we_i && addr_i == CMD_SET_START) ? sel : '0;
endmodule

// File: rtl/dma_chan_bits.sv
module dma_chan_bits #(
  parameter int NUM_CH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_eei_i,
  input  logic [NUM_CH-1:0] clr_eei_i,
  input  logic [NUM_CH-1:0] clr_int_i,
  input  logic [NUM_CH-1:0] clr_err_i,
  input  logic [NUM_CH-1:0] set_start_i,
  input  logic [NUM_CH-1:0] w1c_int_i,
  input  logic [NUM_CH-1:0] w1c_err_i,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [NUM_CH-1:0] err_i,
  output logic [NUM_CH-1:0] eei_o,
  output logic [NUM_CH-1:0] int_o,
  output logic [NUM_CH-1:0] err_o,
  output logic [NUM_CH-1:0] start_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        eei_o[c]   <= 1'b0;
        int_o[c]   <= 1'b0;
        err_o[c]   <= 1'b0;
        start_o[c] <= 1'b0;
      end else begin
        if (set_eei_i[c])      eei_o[c] <= 1'b1;
        else if (clr_eei_i[c]) eei_o[c] <= 1'b0;
        // hardware set wins over a same-cycle clear
        int_o[c]   <= done_i[c] | (int_o[c] & ~(clr_int_i[c] | w1c_int_i[c]));
        err_o[c]   <= (err_i[c] & eei_o[c]) |
                      (err_o[c] & ~(clr_err_i[c] | w1c_err_i[c]));
        start_o[c] <= set_start_i[c];
      end
    end
  end
endmodule

// File: rtl/dma_err_latch.sv
module dma_err_latch
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] err_i,
  input  logic [INFO_W-1:0] err_info_i,
  input  logic [NUM_CH-1:0] clr_err_i,
  output logic [31:0]       status_o
);
  logic              vld_q;
  logic [CH_W-1:0]   ch_q;
  logic [INFO_W-1:0] info_q;
  logic              hit;
  logic [CH_W-1:0]   hit_ch;
  logic              release_w;

  // lowest channel wins a same-cycle tie
  always_comb begin
    hit    = 1'b0;
    hit_ch = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (err_i[i]) begin
        hit    = 1'b1;
        hit_ch = CH_W'(i);
      end
    end
  end

  always_comb begin
    release_w = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (clr_err_i[i] && ch_q == CH_W'(i)) release_w = 1'b1;
    end
    release_w = release_w & vld_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      ch_q   <= '0;
      info_q <= '0;
    end else if (!(vld_q && !release_w) && hit) begin
      vld_q  <= 1'b1;
      ch_q   <= hit_ch;
      info_q <= err_info_i;
    end else if (release_w) begin
      vld_q  <= 1'b0;
      ch_q   <= '0;
      info_q <= '0;
    end
  end

  assign status_o = {vld_q, 15'd0, info_q[9:8], ch_q, info_q[7:0]};
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [NUM_CH-1:0] err_i,
  input  logic [INFO_W-1:0] err_info_i,
  output logic [NUM_CH-1:0] start_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] set_eei, clr_eei, clr_int, clr_err, set_start, w1c_int, w1c_err;
  logic [NUM_CH-1:0] eei_q, int_q, err_q;
  logic [31:0]       status_w;
  logic [MAX_CH-1:0] eei_pad, int_pad, err_pad;

  dma_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .set_eei_o   (set_eei),
    .clr_eei_o   (clr_eei),
    .clr_int_o   (clr_int),
    .clr_err_o   (clr_err),
    .set_start_o (set_start),
    .w1c_int_o   (w1c_int),
    .w1c_err_o   (w1c_err)
  );

  dma_chan_bits #(.NUM_CH(NUM_CH)) u_bits (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_eei_i   (set_eei),
    .clr_eei_i   (clr_eei),
    .clr_int_i   (clr_int),
    .clr_err_i   (clr_err),
    .set_start_i (set_start),
    .w1c_int_i   (w1c_int),
    .w1c_err_i   (w1c_err),
    .done_i      (done_i),
    .err_i       (err_i),
    .eei_o       (eei_q),
    .int_o       (int_q),
    .err_o       (err_q),
    .start_o     (start_o)
  );

  dma_err_latch #(.NUM_CH(NUM_CH)) u_lat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .err_i      (err_i),
    .err_info_i (err_info_i),
    .clr_err_i  (clr_err),
    .status_o   (status_w)
  );

  // unimplemented channels read as zero
  for (genvar c = 0; c < MAX_CH; c++) begin : g_pad
    if (c < NUM_CH) begin : g_on
      assign eei_pad[c] = eei_q[c];
      assign int_pad[c] = int_q[c];
      assign err_pad[c] = err_q[c];
    end else begin : g_off
      assign eei_pad[c] = 1'b0;
      assign int_pad[c] = 1'b0;
      assign err_pad[c] = 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      REG_STATUS: rdata_o = status_w;
      REG_EEI_HI: rdata_o = eei_pad[63:32];
      REG_EEI_LO: rdata_o = eei_pad[31:0];
      REG_INT_HI: rdata_o = int_pad[63:32];
      REG_INT_LO: rdata_o = int_pad[31:0];
      REG_ERR_HI: rdata_o = err_pad[63:32];
      REG_ERR_LO: rdata_o = err_pad[31:0];
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o = (|int_q) | (|(err_q & eei_q));
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [3:0]        addr_i,
  input logic [31:0]       wdata_i,
  input logic [NUM_CH-1:0] done_i,
  input logic [NUM_CH-1:0] err_i,
  input logic [NUM_CH-1:0] start_o,
  input logic              irq_o,
  input logic [NUM_CH-1:0] eei_q,
  input logic [NUM_CH-1:0] err_q,
  input logic [31:0]       status_q
);
  logic is_cmd, bad_ch;
  assign is_cmd = we_i && (addr_i >= 4'd8) && (addr_i <= 4'd12);
  assign bad_ch = ({24'd0, wdata_i[7:0]} >= 32'(NUM_CH));

  // R9
  start_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_o));

  // R9
  start_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o != '0) |-> $past(we_i && addr_i == CMD_SET_START));

  // R6
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q[31] && !(we_i && addr_i == CMD_CLR_ERR)) |=> $stable(status_q));

  // R4
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((err_q & ~$past(err_q)) != '0) |-> ($past(err_i & eei_q) != '0));

  // R8
  bad_ch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmd && bad_ch) |=> ($stable(eei_q) && start_o == '0));

  // R3
  done_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i != '0) |=> irq_o);

  // R10
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(we_i || done_i != '0 || err_i != '0));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .done_i   (done_i),
  .err_i    (err_i),
  .start_o  (start_o),
  .irq_o    (irq_o),
  .eei_q    (eei_q),
  .err_q    (err_q),
  .status_q (status_w)
);

// File: tb/dma_chan_regs_tb.sv
`timescale 1ns/1ps
module dma_chan_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wdata = 32'd0;
  logic [63:0] done_v = '0;
  logic [63:0] err_v = '0;
  logic [9:0]  info = '0;
  logic [31:0] rdata, s_rdata;
  logic [63:0] start;
  logic [15:0] s_start;
  logic        irq, s_irq;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  dma_chan_regs #(.NUM_CH(64)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .done_i(done_v), .err_i(err_v), .err_info_i(info),
    .start_o(start), .irq_o(irq));

  dma_chan_regs #(.NUM_CH(16)) u_small (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(s_rdata), .done_i(done_v[15:0]), .err_i(err_v[15:0]),
    .err_info_i(info), .start_o(s_start), .irq_o(s_irq));

  // behavioural reference for the 64-channel instance
  logic [63:0] m_eei, m_int, m_err, m_start;
  logic        m_vld;
  int          m_ch;
  logic [9:0]  m_info;

  always @(posedge clk or negedge rst_n) begin : model
    logic [63:0] ne, ni, nr, ns;
    int ch;
    bit rel, lock;
    if (!rst_n) begin
      m_eei <= '0; m_int <= '0; m_err <= '0; m_start <= '0;
      m_vld <= 1'b0; m_ch <= 0; m_info <= '0;
    end else begin
      ne = m_eei; ni = m_int; nr = m_err; ns = '0;
      ch = int'(wdata[7:0]);
      if (we && ch < 64) begin
        case (addr)
          4'd8:  ne[ch] = 1'b1;
          4'd9:  ne[ch] = 1'b0;
          4'd10: ni[ch] = 1'b0;
          4'd11: nr[ch] = 1'b0;
          4'd12: ns[ch] = 1'b1;
          default: ;
        endcase
      end
      if (we && addr == 4'd3) ni[63:32] = ni[63:32] & ~wdata;
      if (we && addr == 4'd4) ni[31:0]  = ni[31:0]  & ~wdata;
      if (we && addr == 4'd5) nr[63:32] = nr[63:32] & ~wdata;
      if (we && addr == 4'd6) nr[31:0]  = nr[31:0]  & ~wdata;
      ni = ni | done_v;
      nr = nr | (err_v & m_eei);
      rel  = m_vld && we && addr == 4'd11 && ch == m_ch;
      lock = m_vld && !rel;
      if (!lock && err_v != '0) begin
        m_vld <= 1'b1;
        m_info <= info;
        for (int i = 63; i >= 0; i--) if (err_v[i]) m_ch <= i;
      end else if (rel) begin
        m_vld <= 1'b0; m_ch <= 0; m_info <= '0;
      end
      m_eei <= ne; m_int <= ni; m_err <= nr; m_start <= ns;
    end
  end

  function automatic logic [31:0] m_read(logic [3:0] a);
    case (a)
      4'd0: return {m_vld, 15'd0, m_info[9:8], 6'(m_ch), m_info[7:0]};
      4'd1: return m_eei[63:32];
      4'd2: return m_eei[31:0];
      4'd3: return m_int[63:32];
      4'd4: return m_int[31:0];
      4'd5: return m_err[63:32];
      4'd6: return m_err[31:0];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] a);
    case (a)
      4'd0: return "R6";
      4'd1, 4'd2: return "R2";
      4'd3, 4'd4: return "R3";
      4'd5, 4'd6: return "R4";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model on every cycle, away from the edges
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      #2;
      chk("R9 start_o vs model", start, m_start);
      chk("R10 irq_o vs model", {63'd0, irq}, {63'd0, (|m_int) | (|(m_err & m_eei))});
      chk({tag_of(addr), " rdata vs model"}, {32'd0, rdata}, {32'd0, m_read(addr)});
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v, output logic [31:0] sv);
    addr = a;
    #1;
    v = rdata;
    sv = s_rdata;
  endtask

  task automatic pulse(logic [63:0] d, logic [63:0] e);
    done_v = d; err_v = e;
    @(negedge clk);
    done_v = '0; err_v = '0;
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] v, sv;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(4'(a), v, sv);
      chk("R1 reset read", {32'd0, v}, 64'd0);
    end
    chk("R1 reset irq", {63'd0, irq}, 64'd0);
    chk("R1 reset start", start, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 enable set/clear and placement
    wr(4'd8, 32'd5);
    wr(4'd8, 32'd40);
    rd(4'd2, v, sv); chk("R2 eei lo", {32'd0, v}, 64'h20);
    rd(4'd1, v, sv); chk("R2 eei hi", {32'd0, v}, 64'h100);
    wr(4'd9, 32'd5);
    rd(4'd2, v, sv); chk("R2 eei lo cleared", {32'd0, v}, 64'h0);

    // R3 completion and clear
    pulse(64'h8, '0);
    rd(4'd4, v, sv); chk("R3 int lo set", {32'd0, v}, 64'h8);
    chk("R10 irq from request", {63'd0, irq}, 64'd1);
    wr(4'd10, 32'd3);
    rd(4'd4, v, sv); chk("R3 int lo cleared", {32'd0, v}, 64'h0);
    chk("R10 irq idle", {63'd0, irq}, 64'd0);

    // R3 same-cycle completion beats clear
    done_v = 64'h80;
    wr(4'd10, 32'd7);
    done_v = '0;
    rd(4'd4, v, sv); chk("R3 set wins over clear", {32'd0, v}, 64'h80);
    wr(4'd4, 32'h80);
    rd(4'd4, v, sv); chk("R5 w1c single", {32'd0, v}, 64'h0);
    pulse(64'h6, '0);
    wr(4'd4, 32'h2);
    rd(4'd4, v, sv); chk("R5 w1c selective", {32'd0, v}, 64'h4);
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd4, v, sv); chk("R5 w1c all ones", {32'd0, v}, 64'h0);

    // R4 / R6 error capture
    info = 10'h3A5;
    pulse('0, 64'd1 << 40);
    info = '0;
    rd(4'd5, v, sv); chk("R4 err hi set", {32'd0, v}, 64'h100);
    rd(4'd0, v, sv); chk("R6 status layout", {32'd0, v}, 64'h8000_E8A5);
    chk("R10 irq from error", {63'd0, irq}, 64'd1);
    pulse('0, 64'd1 << 41);
    rd(4'd5, v, sv); chk("R4 disabled channel ignored", {32'd0, v}, 64'h100);
    rd(4'd0, v, sv); chk("R6 latch holds", {32'd0, v}, 64'h8000_E8A5);

    // R7 release
    wr(4'd11, 32'd3);
    rd(4'd0, v, sv); chk("R7 other channel keeps latch", {32'd0, v}, 64'h8000_E8A5);
    wr(4'd11, 32'd40);
    rd(4'd0, v, sv); chk("R7 release", {32'd0, v}, 64'h0);
    rd(4'd5, v, sv); chk("R4 err cleared", {32'd0, v}, 64'h0);

    // R6 tie goes to lowest channel
    wr(4'd8, 32'd10);
    wr(4'd8, 32'd50);
    info = 10'h001;
    pulse('0, (64'd1 << 10) | (64'd1 << 50));
    info = '0;
    rd(4'd0, v, sv); chk("R6 lowest channel", {32'd0, v}, 64'h8000_0A01);
    rd(4'd6, v, sv); chk("R4 err lo", {32'd0, v}, 64'h400);
    rd(4'd5, v, sv); chk("R4 err hi", {32'd0, v}, 64'h40000);
    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, v, sv); chk("R5 err hi w1c", {32'd0, v}, 64'h0);
    rd(4'd6, v, sv); chk("R5 err lo kept", {32'd0, v}, 64'h400);
    rd(4'd0, v, sv); chk("R7 w1c keeps latch", {32'd0, v}, 64'h8000_0A01);

    // R10 masking by enable
    chk("R10 irq enabled error", {63'd0, irq}, 64'd1);
    wr(4'd9, 32'd10);
    chk("R10 irq masked", {63'd0, irq}, 64'd0);
    rd(4'd6, v, sv); chk("R10 flag still readable", {32'd0, v}, 64'h400);
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd11, 32'd10);
    rd(4'd0, v, sv); chk("R7 release second", {32'd0, v}, 64'h0);

    // R8 out-of-range channel numbers
    wr(4'd8, 32'd64);
    wr(4'd8, 32'd200);
    wr(4'd9, 32'd104);
    rd(4'd1, v, sv); chk("R8 eei hi unchanged", {32'd0, v}, 64'h40100);
    rd(4'd2, v, sv); chk("R8 eei lo unchanged", {32'd0, v}, 64'h0);
    wr(4'd12, 32'd70);
    chk("R8 no start strobe", start, 64'd0);

    // R9 start strobe
    wr(4'd12, 32'd33);
    chk("R9 strobe high", start, 64'd1 << 33);
    @(negedge clk);
    chk("R9 strobe self clears", start, 64'd0);

    // R11 reduced configuration
    wr(4'd8, 32'd20);
    wr(4'd8, 32'd15);
    rd(4'd2, v, sv); chk("R11 small eei lo", {32'd0, sv}, 64'h8000);
    rd(4'd1, v, sv); chk("R11 small eei hi zero", {32'd0, sv}, 64'h0);
    pulse(64'hFFFF_FFFF_FFFF_FFFF, '0);
    rd(4'd3, v, sv); chk("R11 small int hi zero", {32'd0, sv}, 64'h0);
    rd(4'd4, v, sv); chk("R11 small int lo", {32'd0, sv}, 64'hFFFF);
    wr(4'd12, 32'd15);
    chk("R11 small start", {48'd0, s_start}, 64'h8000);
    wr(4'd12, 32'd16);
    chk("R11 small out of range start", {48'd0, s_start}, 64'h0);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule